// File: doc/BRIEF.md
# Packed 16-bit Saturating SIMD ALU

This block is a lane-parallel integer ALU for media-style arithmetic. It splits two wide operands into independent 16-bit lanes (four lanes of a 64-bit word by default) and applies one operation to every lane at once. Carries and borrows never cross a lane boundary. The available operations are:

- add and subtract, each with a choice of wraparound, signed clamping or unsigned clamping;
- a rounding average;
- add-after-shift, where operand A is shifted by a small amount before the add;
- plain lane shifts, arithmetic right, logical right and left.

The datapath is purely combinational per lane. An optional output register, present by default, gives a fixed one-cycle latency. A pipeline places the opcode, the clamping mode, the shift amount and both operands on the inputs and reads the packed result on the following cycle. Each result lane is a function of the same lane of the two operands and nothing else.

Top module: `simd16_alu`

## Requirements
- R1: Each 16-bit result lane depends only on the same lane of A and B. A carry or borrow out of one lane never changes a neighbouring lane.
- R2: Opcode 0 is add and opcode 1 is subtract (A minus B). With mode 0 or mode 3 they wrap modulo 2^16.
- R3: With mode 1, add and subtract treat lanes as two's complement and clamp the true result to the range 0x8000..0x7FFF.
- R4: With mode 2, add and subtract treat lanes as unsigned. An add that overflows gives 0xFFFF, and a subtract that goes below zero gives 0x0000.
- R5: Opcode 2 gives the unsigned average (A+B+1)>>1 for each lane, computed without overflow.
- R6: Opcode 3 shifts the signed A lane left by shamt[1:0] bits (0 to 3), adds the signed B lane, and clamps to 0x8000..0x7FFF. A lane that overflows during the shift still clamps correctly, and shamt[3:2] has no effect.
- R7: Opcode 4 shifts the signed A lane arithmetically right by shamt[1:0] bits, adds the signed B lane, and clamps to 0x8000..0x7FFF.
- R8: Opcode 5 shifts A arithmetically right by shamt (0 to 15), opcode 6 shifts it logically right, and opcode 7 shifts it left with zero fill. B is ignored for these opcodes.
- R9: With OUT_REG=1 the result appears exactly one clock after the inputs are applied. A synchronous active-high reset clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select (encodings in R2, R5 to R8) |
| mode_i | input | 2 | Clamping mode for add/subtract (encodings in R2 to R4) |
| shamt_i | input | 4 | Shift amount |
| opa_i | input | 64 | Packed operand A |
| opb_i | input | 64 | Packed operand B |
| res_o | output | 64 | Packed result |

## Verification
The bench builds the block with its defaults: four lanes and the output register present. This exposes both the lane-isolation boundaries and the one-cycle timing. Every lane of every vector is compared against a behavioural integer model. The vectors are directed corners built from 0x0000, 0x7FFF, 0x8000 and 0xFFFF, plus a random sweep over all opcodes, modes and shift amounts. Lane-to-lane independence is checked by putting an overflowing pattern in one lane next to quiet lanes. The reset value is checked, and so is the rule that shamt[3:2] has no effect on the add-after-shift operations.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int LANE_W = 16;
    localparam int EXT_W  = LANE_W + 4;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_AVG    = 3'd2,
        OP_SHLADD = 3'd3,
        OP_SHRADD = 3'd4,
        OP_SHRS   = 3'd5,
        OP_SHRU   = 3'd6,
        OP_SHL    = 3'd7
    } simd_op_e;

    typedef enum logic [1:0] {
        MODE_WRAP  = 2'd0,
        MODE_SSAT  = 2'd1,
        MODE_USAT  = 2'd2,
        MODE_WRAP2 = 2'd3
    } sat_mode_e;

    typedef struct packed {
        simd_op_e  op;
        sat_mode_e mode;
        logic [3:0] shamt;
    } lane_ctl_t;

    localparam logic signed [EXT_W-1:0] SMAX = EXT_W'(2 ** (LANE_W - 1) - 1);
    localparam logic signed [EXT_W-1:0] SMIN = -EXT_W'(2 ** (LANE_W - 1));

    function automatic logic [LANE_W-1:0] clamp_signed(input logic signed [EXT_W-1:0] v);
        if (v > SMAX)      return {1'b0, {(LANE_W-1){1'b1}}};
        else if (v < SMIN) return {1'b1, {(LANE_W-1){1'b0}}};
        else               return v[LANE_W-1:0];
    endfunction

    function automatic logic signed [EXT_W-1:0] sext(input logic [LANE_W-1:0] x);
        return {{(EXT_W-LANE_W){x[LANE_W-1]}}, x};
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
(
    input  lane_ctl_t         ctl,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);
    logic signed [EXT_W-1:0] sa, sb, ssum, sdiff, shl_sum, shr_sum;
    logic [LANE_W:0]         usum, udiff, avg_sum;
    logic signed [LANE_W-1:0] a_s;
    logic [1:0]              sh2;

    always_comb begin
        sa      = sext(a);
        sb      = sext(b);
        a_s     = a;
        sh2     = ctl.shamt[1:0];
        ssum    = sa + sb;
        sdiff   = sa - sb;
        usum    = {1'b0, a} + {1'b0, b};
        udiff   = {1'b0, a} - {1'b0, b};
        avg_sum = usum + (LANE_W+1)'(1);
        shl_sum = (sa <<< sh2) + sb;
        shr_sum = (sa >>> sh2) + sb;

        unique case (ctl.op)
            OP_ADD: begin
                unique case (ctl.mode)
                    MODE_SSAT: y = clamp_signed(ssum);
                    MODE_USAT: y = usum[LANE_W] ? {LANE_W{1'b1}} : usum[LANE_W-1:0];
                    default:   y = usum[LANE_W-1:0];
                endcase
            end
            OP_SUB: begin
                unique case (ctl.mode)
                    MODE_SSAT: y = clamp_signed(sdiff);
                    MODE_USAT: y = udiff[LANE_W] ? {LANE_W{1'b0}} : udiff[LANE_W-1:0];
                    default:   y = udiff[LANE_W-1:0];
                endcase
            end
            OP_AVG:    y = avg_sum[LANE_W:1];
            OP_SHLADD: y = clamp_signed(shl_sum);
            OP_SHRADD: y = clamp_signed(shr_sum);
            OP_SHRS:   y = a_s >>> ctl.shamt;
            OP_SHRU:   y = a >> ctl.shamt;
            default:   y = a << ctl.shamt;
        endcase
    end

    always_comb begin
        if (ctl.op == OP_ADD && ctl.mode == MODE_USAT)
            assert_usat_add_R4 : assert (y >= a && y >= b);
        if (ctl.op == OP_SUB && ctl.mode == MODE_USAT)
            assert_usat_sub_R4 : assert (y <= a);
        if (ctl.op == OP_ADD && ctl.mode == MODE_SSAT && !a[LANE_W-1] && !b[LANE_W-1])
            assert_ssat_pos_R3 : assert (!y[LANE_W-1]);
        if (ctl.op == OP_AVG)
            assert_avg_bounds_R5 : assert ((y >= a || y >= b) && (y <= a || y <= b));
    end
endmodule

// File: rtl/simd_outreg.sv
module simd_outreg #(
    parameter int WIDTH   = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_pass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/simd16_alu.sv
module simd16_alu
    import simd_pkg::*;
#(
    parameter int LANES   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              op_i,
    input  logic [1:0]              mode_i,
    input  logic [3:0]              shamt_i,
    input  logic [LANES*LANE_W-1:0] opa_i,
    input  logic [LANES*LANE_W-1:0] opb_i,
    output logic [LANES*LANE_W-1:0] res_o
);
    localparam int WIDTH = LANES * LANE_W;

    lane_ctl_t        ctl;
    logic [WIDTH-1:0] lane_res;

    assign ctl.op    = simd_op_e'(op_i);
    assign ctl.mode  = sat_mode_e'(mode_i);
    assign ctl.shamt = shamt_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_lane u_lane (
            .ctl (ctl),
            .a   (opa_i[g*LANE_W +: LANE_W]),
            .b   (opb_i[g*LANE_W +: LANE_W]),
            .y   (lane_res[g*LANE_W +: LANE_W])
        );
    end

    simd_outreg #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (lane_res),
        .q   (res_o)
    );

    generate
        if (OUT_REG) begin : g_chk
            logic seen_clk;
            always_ff @(posedge clk) seen_clk <= 1'b1;

            assert_reg_latency_R9 : assert property (@(posedge clk) disable iff (rst)
                (seen_clk && !$past(rst)) |-> (res_o == $past(lane_res)));
            assert_reset_clear_R9 : assert property (@(posedge clk)
                (seen_clk && $past(rst)) |-> (res_o == '0));
        end
    endgenerate
endmodule

// File: tb/simd16_alu_test.sv
module simd16_alu_test;
    localparam int LANES = 4;
    localparam int W = LANES * 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op = '0;
    logic [1:0]   md = '0;
    logic [3:0]   sh = '0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] res;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    simd16_alu #(.LANES(LANES), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .op_i(op), .mode_i(md), .shamt_i(sh),
        .opa_i(a), .opb_i(b), .res_o(res)
    );

    function automatic int sx(int x);
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    function automatic int clamp_s(int v);
        if (v > 32767) return 32'h7FFF;
        if (v < -32768) return 32'h8000;
        return v & 32'hFFFF;
    endfunction

    function automatic int ref_lane(int o, int m, int s, int x, int y);
        int sa = sx(x);
        int sb = sx(y);
        int s2 = s % 4;
        case (o)
            0: if (m == 1) return clamp_s(sa + sb);
               else if (m == 2) return (x + y > 65535) ? 65535 : x + y;
               else return (x + y) & 32'hFFFF;
            1: if (m == 1) return clamp_s(sa - sb);
               else if (m == 2) return (x < y) ? 0 : x - y;
               else return (x - y) & 32'hFFFF;
            2: return (x + y + 1) / 2;
            3: return clamp_s(sa * (1 << s2) + sb);
            4: return clamp_s((sa >>> s2) + sb);
            5: return (sa >>> s) & 32'hFFFF;
            6: return x >> s;
            default: return (x << s) & 32'hFFFF;
        endcase
    endfunction

    function automatic string req_of(int o, int m);
        case (o)
            0, 1: return (m == 1) ? "R3" : (m == 2) ? "R4" : "R2";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(int o, int m, int s, logic [W-1:0] va, logic [W-1:0] vb, string tag);
        logic [W-1:0] exp;
        @(negedge clk);
        op = 3'(o); md = 2'(m); sh = 4'(s); a = va; b = vb;
        for (int l = 0; l < LANES; l++)
            exp[l*16 +: 16] = 16'(ref_lane(o, m, s, int'(va[l*16 +: 16]), int'(vb[l*16 +: 16])));
        @(posedge clk);
        #1;
        checks++;
        if (res !== exp) begin
            errors++;
            $display("FAIL %s (%s R9) op=%0d mode=%0d sh=%0d actual=%h expected=%h",
                     req_of(o, m), tag, o, m, s, res, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] corner [4];
        logic [W-1:0] ra, rb;
        corner[0] = {4{16'h0000}};
        corner[1] = {4{16'h7FFF}};
        corner[2] = {4{16'h8000}};
        corner[3] = {4{16'hFFFF}};

        // R9: reset clears the result
        a = {4{16'h1234}}; b = {4{16'h4321}};
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (res !== '0) begin
            errors++;
            $display("FAIL R9 reset actual=%h expected=%h", res, {W{1'b0}});
        end
        @(negedge clk); rst = 0;

        // R1: lane 0 overflows, neighbours must stay quiet
        apply(0, 0, 0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, "R1 carry cut");
        apply(1, 0, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, "R1 borrow cut");
        apply(0, 2, 0, 64'h0001_7FFF_FFFF_0000, 64'h0002_0001_0001_0000, "R1 mixed lanes");

        // directed corners for every opcode and mode
        for (int o = 0; o < 8; o++)
            for (int m = 0; m < 4; m++)
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        apply(o, m, (o >= 5) ? 15 : 3, corner[i], corner[j], "corner");

        // R6: shamt[3:2] ignored, overflow on shift saturates
        apply(3, 0, 4'b1101, {16'h4000, 16'hC000, 16'h7FFF, 16'h0001}, {16'h0000, 16'h0000, 16'h8000, 16'h7FFF}, "R6 upper shamt");
        apply(3, 0, 4'b0011, {16'h2000, 16'hD000, 16'h7FFF, 16'h8000}, {16'h0000, 16'h0000, 16'h0000, 16'h0000}, "R6 shift overflow");
        apply(4, 0, 4'b0110, {16'h8000, 16'h7FFF, 16'hFFFF, 16'h0004}, {16'h8000, 16'h7FFF, 16'h0001, 16'h7FFF}, "R7 clamp");

        // random sweep
        for (int k = 0; k < 1500; k++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (k % 5 == 0) ra[15:0] = corner[k % 4][15:0];
            if (k % 7 == 0) rb[31:16] = corner[(k / 7) % 4][15:0];
            apply(k % 8, (k / 8) % 4, $urandom % 16, ra, rb, "random");
        end

        // R9: reset mid-stream clears the result
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        checks++;
        if (res !== '0) begin
            errors++;
            $display("FAIL R9 mid reset actual=%h expected=%h", res, {W{1'b0}});
        end
        finish_run();
    end
endmodule